// File: doc/BRIEF.md
# Cascadable Segment Data Loader

This block receives display data over a parallel bus, one word per shift-clock edge, and writes it into a 240-bit data latch that feeds a column driver. The bus is either a full byte wide or a nibble wide. In nibble mode two consecutive edges make up one byte. A direction input decides whether the latch fills from its low index upward or from its high index downward.

Several loaders can share one data bus and be chained through their enable pins. A load pulse arms every device. Each armed device waits until the enable arriving at its input pin goes low. It then takes bytes on every edge until it has 30 of them, drops its enable output for exactly one cycle to hand over to the next device, and ignores the bus until it is armed again. Which of the two enable pins serves as input and which as output depends on the fill direction, so a chain can run either way.

Top module: `seg_loader`

## Requirements
- R1: After reset the latch holds all zeros and both enable outputs are high. Clock edges do nothing until the first load pulse, whatever the enable input does.
- R2: Byte mode (`nibble_mode`=0) with forward fill (`fill_fwd`=1): the k-th accepted byte (k counted from 0) puts `din[j]` into `latch_q[8k+j]`.
- R3: Reverse fill (`fill_fwd`=0): the k-th accepted byte puts bit j into `latch_q[239-8k-j]`.
- R4: Nibble mode (`nibble_mode`=1): each byte takes two edges and only `din[3:0]` is used. The first nibble becomes byte bits 3..0 and the second becomes bits 7..4, so the first nibble lands in the positions filled first in the current direction.
- R5: With `fill_fwd`=0, pin 1 is the enable output (`en1_oe`=1, `en2_oe`=0) and `en2_in` is the enable input. With `fill_fwd`=1 the roles swap. An enable level on the output-side pin has no effect.
- R6: After a load pulse, selection begins on the first edge at which the enable input is low, and the data on that edge is accepted. From then on the enable input level does not matter.
- R7: After the 30th byte the block deselects, and further edges leave the latch unchanged.
- R8: The enable output goes low for exactly one clock cycle, the cycle that follows the edge writing the 30th byte. At all other times it is high.
- R9: When the block is armed and the enable input is high, clock edges leave the latch unchanged.
- R10: A load pulse in the middle of a window restarts the byte count at slot 0 and drops any half-received nibble. Bytes already written stay in the latch. No data is accepted on the edge that carries the load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; data is sampled on its active edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp | input | 1 | Load pulse: arms the block and restarts the sequence |
| nibble_mode | input | 1 | 1: 4-bit bus, 0: 8-bit bus |
| fill_fwd | input | 1 | 1: fill from index 0 upward, 0: from index 239 downward |
| din | input | 8 | Parallel display data |
| en1_in | input | 1 | Enable pin 1, input value |
| en1_out | output | 1 | Enable pin 1, output value |
| en1_oe | output | 1 | Enable pin 1, output enable |
| en2_in | input | 1 | Enable pin 2, input value |
| en2_out | output | 1 | Enable pin 2, output value |
| en2_oe | output | 1 | Enable pin 2, output enable |
| latch_q | output | 240 | Data latch contents |

## Verification
A full 30-byte window is loaded under all four combinations of bus width and fill direction, each with a different seeded byte pattern. Comparing the whole latch separates a bit-order mistake from a byte-order mistake and from a nibble-pairing mistake. Directed sequences cover the rest: edges before the first load pulse, edges while the enable input is high, edges after the window is full, a load pulse that arrives between nibbles, and the enable level placed on the output-side pin instead of the input-side pin. Each of these can only pass if the latch stays exactly as the model predicts.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/seg_loader_ctrl.sv
module seg_loader_ctrl #(
  parameter int SLOTS = 30,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp,
  input  logic             en_in,
  input  logic             wr,
  output logic             accept,
  output logic [CNT_W-1:0] slot,
  output logic             chain_n
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic             armed_q, armed_d;
  logic             sel_q, sel_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept  = !lp && (sel_q || (armed_q && !en_in));
  assign slot    = cnt_q;
  assign chain_n = !done_q;

  always_comb begin
    armed_d = armed_q;
    sel_d   = sel_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (lp) begin
      armed_d = 1'b1;
      sel_d   = 1'b0;
      cnt_d   = '0;
    end else begin
      if (accept) begin
        sel_d   = 1'b1;
        armed_d = 1'b0;
      end
      if (wr) begin
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          sel_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      sel_q   <= sel_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/seg_loader_pack.sv
module seg_loader_pack
  import seg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp,
  input  logic              accept,
  input  logic              nibble_mode,
  input  logic [BYTE_W-1:0] din,
  output logic              wr,
  output logic [BYTE_W-1:0] wdata
);
  logic             half_q, half_d;
  logic [NIB_W-1:0] nib_q;
  logic             nib_en;

  assign wr     = accept && (!nibble_mode || half_q);
  assign wdata  = nibble_mode ? {din[NIB_W-1:0], nib_q} : din;
  assign nib_en = accept && nibble_mode && !half_q;

  always_comb begin
    half_d = half_q;
    if (lp)          half_d = 1'b0;
    else if (accept) half_d = nibble_mode ? !half_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      nib_q  <= '0;
    end else begin
      half_q <= half_d;
      if (nib_en) nib_q <= din[NIB_W-1:0];
    end
  end
endmodule

// File: rtl/seg_loader_latch.sv
module seg_loader_latch
  import seg_loader_pkg::*;
#(
  parameter int SLOTS = 30,
  parameter int CNT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [CNT_W-1:0]        slot,
  input  logic                    fill_fwd,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [SLOTS*BYTE_W-1:0] q
);
  logic [BYTE_W-1:0] wdata_rev;
  assign wdata_rev = rev_byte(wdata);

  for (genvar g = 0; g < SLOTS; g++) begin : g_grp
    logic              hit;
    logic [BYTE_W-1:0] grp_q;
    assign hit = fill_fwd ? (slot == CNT_W'(g)) : (slot == CNT_W'(SLOTS - 1 - g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          grp_q <= '0;
      else if (wr && hit)  grp_q <= fill_fwd ? wdata : wdata_rev;
    end
    assign q[g*BYTE_W +: BYTE_W] = grp_q;
  end
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_loader_pkg::*;
#(
  parameter int LATCH_BITS = 240
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lp,
  input  logic                  nibble_mode,
  input  logic                  fill_fwd,
  input  logic [BYTE_W-1:0]     din,
  input  logic                  en1_in,
  output logic                  en1_out,
  output logic                  en1_oe,
  input  logic                  en2_in,
  output logic                  en2_out,
  output logic                  en2_oe,
  output logic [LATCH_BITS-1:0] latch_q
);
  localparam int SLOTS = LATCH_BITS / BYTE_W;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              en_in;
  logic              accept;
  logic              wr;
  logic              chain_n;
  logic [CNT_W-1:0]  slot;
  logic [BYTE_W-1:0] wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign en_in   = fill_fwd ? en1_in : en2_in;
  assign en1_oe  = !fill_fwd;
  assign en2_oe  = fill_fwd;
  assign en1_out = chain_n;
  assign en2_out = chain_n;

  seg_loader_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .lp(lp), .en_in(en_in), .wr(wr),
    .accept(accept), .slot(slot), .chain_n(chain_n)
  );

  seg_loader_pack u_pack (
    .clk(clk), .rst_n(rst_sync_n), .lp(lp), .accept(accept),
    .nibble_mode(nibble_mode), .din(din), .wr(wr), .wdata(wdata)
  );

  seg_loader_latch #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .wr(wr), .slot(slot),
    .fill_fwd(fill_fwd), .wdata(wdata), .q(latch_q)
  );
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk #(
  parameter int LATCH_BITS = 240,
  parameter int SLOTS      = 30,
  parameter int CNT_W      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fill_fwd,
  input logic                  nibble_mode,
  input logic                  en1_oe,
  input logic                  en2_oe,
  input logic                  en1_out,
  input logic                  accept,
  input logic                  wr,
  input logic [CNT_W-1:0]      slot,
  input logic [LATCH_BITS-1:0] latch_q
);
  // R5
  pin_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_oe != en2_oe) && (en1_oe == !fill_fwd));

  // R8
  chain_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en1_out |=> en1_out);

  // R8
  chain_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en1_out) |-> $past(wr));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(latch_q));

  // R4
  nibble_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nibble_mode && wr) |=> !(nibble_mode && wr));

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= CNT_W'(SLOTS - 1));
endmodule

bind seg_loader seg_loader_chk #(
  .LATCH_BITS(LATCH_BITS), .SLOTS(SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_fwd(fill_fwd), .nibble_mode(nibble_mode),
  .en1_oe(en1_oe), .en2_oe(en2_oe), .en1_out(en1_out), .accept(accept),
  .wr(wr), .slot(slot), .latch_q(latch_q)
);

// File: tb/seg_loader_tb.sv
`timescale 1ns/1ps
module seg_loader_tb;
  localparam int NB = 240;
  localparam int NS = 30;

  logic          clk = 1'b0;
  logic          rst_n, lp, nibble_mode, fill_fwd, en1_in, en2_in;
  logic [7:0]    din;
  logic          en1_out, en1_oe, en2_out, en2_oe;
  logic [NB-1:0] latch_q;
  logic [NB-1:0] model;
  int            errors = 0;
  int            checks = 0;
  bit            finished = 1'b0;

  always #2.5 clk = !clk;

  seg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .lp(lp), .nibble_mode(nibble_mode),
    .fill_fwd(fill_fwd), .din(din), .en1_in(en1_in), .en1_out(en1_out),
    .en1_oe(en1_oe), .en2_in(en2_in), .en2_out(en2_out), .en2_oe(en2_oe),
    .latch_q(latch_q)
  );

  // {nibble_mode, fill_fwd, seed}
  localparam logic [9:0] VEC [4] = '{
    {1'b0, 1'b1, 8'h11}, {1'b0, 1'b0, 8'hC3},
    {1'b1, 1'b1, 8'h5A}, {1'b1, 1'b0, 8'h96}
  };

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return (seed ^ 8'(k * 27)) + 8'(k);
  endfunction

  task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_en(input logic v);
    en1_in = v;
    en2_in = v;
  endtask

  task automatic pulse_lp();
    lp = 1'b1;
    cyc();
    lp = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    if (nibble_mode) begin
      din = {4'hA, b[3:0]};
      cyc();
      din = {4'h5, b[7:4]};
      cyc();
    end else begin
      din = b;
      cyc();
    end
  endtask

  task automatic put(input int k, input logic [7:0] b);
    for (int j = 0; j < 8; j++) begin
      if (fill_fwd) model[8*k + j] = b[j];
      else          model[NB-1 - 8*k - j] = b[j];
    end
  endtask

  function automatic logic out_pin();
    return fill_fwd ? en2_out : en1_out;
  endfunction

  // Loads a full window; the enable input is low only for the first byte.
  task automatic window(input logic [7:0] seed, input string tag);
    for (int k = 0; k < NS; k++) begin
      if (k == 0) set_en(1'b0);
      send(pat(seed, k));
      put(k, pat(seed, k));
      if (k == 0) set_en(1'b1);
      if (k == NS - 1) begin
        chk({tag, " R8 chain low after byte 30"}, NB'(out_pin()), NB'(0));
      end
    end
    chk({tag, " latch contents"}, latch_q, model);
    cyc();
    chk({tag, " R8 chain high again"}, NB'(out_pin()), NB'(1));
  endtask

  initial begin
    rst_n = 1'b0; lp = 1'b0; nibble_mode = 1'b0; fill_fwd = 1'b1;
    din = '0; set_en(1'b1); model = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    chk("R1 latch after reset", latch_q, '0);
    chk("R1 enable outputs high", NB'({en1_out, en2_out}), NB'(2'b11));
    // R1 edges before any load pulse are ignored
    set_en(1'b0);
    send(8'hFF);
    send(8'h81);
    set_en(1'b1);
    chk("R1 no load before first LP", latch_q, model);

    // table: R2 (fwd byte), R3 (reverse), R4 (nibble both directions), R6
    for (int v = 0; v < 4; v++) begin
      nibble_mode = VEC[v][9];
      fill_fwd    = VEC[v][8];
      pulse_lp();
      window(VEC[v][7:0], $sformatf("R2/R3/R4/R6 vec%0d", v));
    end

    // R9 armed but enable input high
    nibble_mode = 1'b0; fill_fwd = 1'b1;
    pulse_lp();
    send(8'h00); send(8'hEE); send(8'h77);
    chk("R9 armed with enable high", latch_q, model);
    window(8'h3D, "R9 window after wait");

    // R7 edges after the window ends
    set_en(1'b0);
    send(8'h0F); send(8'hF0);
    set_en(1'b1);
    chk("R7 latch frozen after 30 bytes", latch_q, model);
    chk("R7 no second chain pulse", NB'(out_pin()), NB'(1));

    // R10 restart between nibbles
    nibble_mode = 1'b1; fill_fwd = 1'b1;
    pulse_lp();
    set_en(1'b0);
    for (int k = 0; k < 5; k++) begin
      send(pat(8'h44, k));
      put(k, pat(8'h44, k));
    end
    set_en(1'b1);
    din = 8'h0C;
    cyc();
    chk("R10 partial window written", latch_q, model);
    pulse_lp();
    window(8'hB7, "R10 restarted window");

    // R5 pin roles and input-side selection
    nibble_mode = 1'b0; fill_fwd = 1'b0;
    #1;
    chk("R5 reverse roles", NB'({en1_oe, en2_oe}), NB'(2'b10));
    pulse_lp();
    en1_in = 1'b0; en2_in = 1'b1;
    send(8'hA5);
    chk("R5 output-side enable ignored", latch_q, model);
    en2_in = 1'b0;
    send(8'h3C);
    put(0, 8'h3C);
    chk("R5 input-side enable selects", latch_q, model);
    fill_fwd = 1'b1;
    #1;
    chk("R5 forward roles", NB'({en1_oe, en2_oe}), NB'(2'b01));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule